// File: doc/BRIEF.md
# Replica-Tap DVFS Step Decider

This block sits between a pair of on-chip timing replica chains and the voltage/frequency manager. Each chain reports a captured vector of seven tap flags, where a set flag means the transition reached that tap too close to the capturing clock edge. Tap 1 is the most sensitive tap. The block turns each vector into a level from 0 to 7 and keeps the worse (larger) of the two levels. It then compares that level with a target count and issues one step request.

The target count comes from an offline calibration run. It is written through a load strobe and resets to 4, which means taps 1 to 4 tripped and taps 5 to 7 clear. Raising the clock or lowering the supply trips more taps. A mode input chooses how the block reacts:

- In performance mode, the block moves the clock toward the target.
- In power mode, the block moves the supply toward the target.

A level above the target always asks for the safe direction.

The controller has two states:

- **WAIT_VEC**: the block is ready for a vector.
- **HOLD_REQ**: a request is presented and waits for its acknowledge.

It has two transitions:

- **accept**: WAIT_VEC to HOLD_REQ, on `vec_valid` with `vec_ready`.
- **release**: HOLD_REQ to WAIT_VEC, on `req_ack`.

Top module: `dvfs_step_decider`

## Requirements
- R1: After reset, `vec_ready` is 1, `req_valid` is 0 and `tap_gap_err` is 0. The target count is `DEFAULT_TARGET` (4).
- R2: The level of one chain is the index of its highest set flag plus one, where bit 0 is tap 1. A vector with no flag set gives level 0.
- R3: The level used for the decision is the larger of the two chain levels.
- R4: With `mode_power`=0, a level below the target gives `req_code`=1 (raise clock). A level above the target gives `req_code`=2 (lower clock).
- R5: With `mode_power`=1, a level below the target gives `req_code`=3 (lower supply). A level above the target gives `req_code`=4 (raise supply).
- R6: A level equal to the target gives `req_code`=0 (hold).
- R7: On the clock edge where `vec_valid` and `vec_ready` are both 1, the vector is accepted. From the next cycle, `req_valid` is 1 and `req_code` stays unchanged until an edge where `req_ack` is 1. After that edge, `req_valid` is 0 and `vec_ready` is 1.
- R8: While a request is pending, `vec_ready` is 0. Vectors offered during that time produce no further request and do not change `req_code`.
- R9: An accepted vector in which either chain has a set flag above a clear flag sets `tap_gap_err`. The flag stays set until reset. The decision still uses the level from the highest set flag.
- R10: `cal_load` writes `cal_target` into the target count at the clock edge. A vector accepted at that same edge is judged against the previous target. `mode_power` is sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_valid | input | 1 | A flag vector pair is offered |
| vec_ready | output | 1 | Block can accept a vector pair |
| nor_taps | input | TAPS (7) | Flags from the pull-up-ageing replica chain, bit 0 = tap 1 |
| nand_taps | input | TAPS (7) | Flags from the pull-down-ageing replica chain, bit 0 = tap 1 |
| mode_power | input | 1 | 0 = performance goal, 1 = power goal |
| cal_load | input | 1 | Write strobe for the target count |
| cal_target | input | CW (3) | New target count |
| req_valid | output | 1 | Step request presented |
| req_code | output | 3 | 0 hold, 1 raise clock, 2 lower clock, 3 lower supply, 4 raise supply |
| req_ack | input | 1 | Manager has taken the request |
| tap_gap_err | output | 1 | Sticky: a non-contiguous tap pattern was seen |

## Verification
A target write and a vector acceptance can fall on the same clock edge. The bench provokes this by raising `cal_load` with a new target in the same cycle as `vec_valid`. It chooses the level so that the old target and the new target call for different requests, and it expects the request from the old target. A second vector is then checked against the new target. The random phase also lets calibration writes and vectors coincide at will, and the bench model applies the same old-target rule.

// File: rtl/dvfs_step_pkg.sv
package dvfs_step_pkg;

    typedef enum logic [2:0] {
        REQ_HOLD      = 3'd0,
        REQ_CLK_UP    = 3'd1,
        REQ_CLK_DOWN  = 3'd2,
        REQ_VDD_DOWN  = 3'd3,
        REQ_VDD_UP    = 3'd4
    } step_req_e;

    typedef enum logic [0:0] {
        ST_WAIT_VEC = 1'b0,
        ST_HOLD_REQ = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/tap_level.sv
module tap_level #(
    parameter int TAPS = 7,
    localparam int CW = $clog2(TAPS + 1)
) (
    input  logic [TAPS-1:0] taps,
    output logic [CW-1:0]   level,
    output logic            gap
);
    logic [TAPS-1:0] thermo;

    // Highest tripped tap wins; bit 0 is the most sensitive tap.
    always_comb begin
        level = '0;
        for (int i = 0; i < TAPS; i++) begin
            if (taps[i]) level = CW'(i + 1);
        end
    end

    // A contiguous pattern equals the thermometer code of its own level.
    always_comb begin
        for (int i = 0; i < TAPS; i++) begin
            thermo[i] = (i < int'(level));
        end
        gap = |(taps ^ thermo);
    end

endmodule

// File: rtl/step_policy.sv
module step_policy
    import dvfs_step_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic [CW-1:0] lvl_a,
    input  logic [CW-1:0] lvl_b,
    input  logic [CW-1:0] target,
    input  logic          power_goal,
    output logic [CW-1:0] worst,
    output step_req_e     code
);
    always_comb begin
        worst = (lvl_a > lvl_b) ? lvl_a : lvl_b;
        // Over-target is the timing-risk case and is tested first.
        if (worst > target) begin
            code = power_goal ? REQ_VDD_UP : REQ_CLK_DOWN;
        end else if (worst < target) begin
            code = power_goal ? REQ_VDD_DOWN : REQ_CLK_UP;
        end else begin
            code = REQ_HOLD;
        end
    end

endmodule

// File: rtl/dvfs_step_decider.sv
module dvfs_step_decider
    import dvfs_step_pkg::*;
#(
    parameter int TAPS           = 7,
    parameter int DEFAULT_TARGET = 4,
    localparam int CW            = $clog2(TAPS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vec_valid,
    output logic            vec_ready,
    input  logic [TAPS-1:0] nor_taps,
    input  logic [TAPS-1:0] nand_taps,
    input  logic            mode_power,
    input  logic            cal_load,
    input  logic [CW-1:0]   cal_target,
    output logic            req_valid,
    output logic [2:0]      req_code,
    input  logic            req_ack,
    output logic            tap_gap_err
);
    ctl_state_e      state_q, state_d;
    logic [CW-1:0]   target_q;
    logic [CW-1:0]   nor_lvl, nand_lvl, worst_lvl;
    logic            nor_gap, nand_gap;
    step_req_e       code_now;
    step_req_e       code_q;
    logic            err_q;
    logic            accept;

    tap_level #(.TAPS(TAPS)) u_nor_level (
        .taps (nor_taps),
        .level(nor_lvl),
        .gap  (nor_gap)
    );

    tap_level #(.TAPS(TAPS)) u_nand_level (
        .taps (nand_taps),
        .level(nand_lvl),
        .gap  (nand_gap)
    );

    step_policy #(.CW(CW)) u_policy (
        .lvl_a     (nor_lvl),
        .lvl_b     (nand_lvl),
        .target    (target_q),
        .power_goal(mode_power),
        .worst     (worst_lvl),
        .code      (code_now)
    );

    assign accept = vec_valid && (state_q == ST_WAIT_VEC);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_VEC: if (vec_valid) state_d = ST_HOLD_REQ;
            ST_HOLD_REQ: if (req_ack)   state_d = ST_WAIT_VEC;
            default:     state_d = ST_WAIT_VEC;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_VEC;
        else        state_q <= state_d;
    end

    // Registered outputs, target count and sticky error.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= REQ_HOLD;
            err_q    <= 1'b0;
            target_q <= CW'(DEFAULT_TARGET);
        end else begin
            if (cal_load) target_q <= cal_target;
            if (accept) begin
                code_q <= code_now;
                if (nor_gap || nand_gap) err_q <= 1'b1;
            end
        end
    end

    assign vec_ready   = (state_q == ST_WAIT_VEC);
    assign req_valid   = (state_q == ST_HOLD_REQ);
    assign req_code    = code_q;
    assign tap_gap_err = err_q;

    a_r7_req_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_ready) |=> (req_valid && !vec_ready));

    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_code)));

    a_r8_no_ready_pending: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !vec_ready);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tap_gap_err |=> tap_gap_err);

    a_r4_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_code <= 3'd4));

endmodule

// File: tb/dvfs_step_decider_bench.sv
module dvfs_step_decider_bench;
    localparam int  TAPS     = 7;
    localparam int  CW       = 3;
    localparam time CLK_HALF = 5ns;
    localparam int  WATCHDOG = 100000;

    logic clk = 0;
    logic rst_n = 0;
    logic vec_valid = 0;
    logic vec_ready;
    logic [TAPS-1:0] nor_taps = '0, nand_taps = '0;
    logic mode_power = 0;
    logic cal_load = 0;
    logic [CW-1:0] cal_target = '0;
    logic req_valid;
    logic [2:0] req_code;
    logic req_ack = 0;
    logic tap_gap_err;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int cycles = 0;
    int model_target = 4;
    bit model_err = 0;

    dvfs_step_decider u_dvfs_step_decider (
        .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
        .nor_taps(nor_taps), .nand_taps(nand_taps), .mode_power(mode_power),
        .cal_load(cal_load), .cal_target(cal_target), .req_valid(req_valid),
        .req_code(req_code), .req_ack(req_ack), .tap_gap_err(tap_gap_err)
    );

    always #(CLK_HALF) clk = ~clk;

    function automatic int lvl_of(logic [TAPS-1:0] f);
        int l = 0;
        for (int i = 0; i < TAPS; i++) if (f[i]) l = i + 1;
        return l;
    endfunction

    function automatic bit gap_of(logic [TAPS-1:0] f);
        int l = lvl_of(f);
        for (int i = 0; i < TAPS; i++) if (f[i] != (i < l)) return 1;
        return 0;
    endfunction

    function automatic int code_of(int a, int b, int t, bit pw);
        int w = (a > b) ? a : b;
        if (w > t) return pw ? 4 : 2;
        if (w < t) return pw ? 3 : 1;
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Offer one vector (optionally with a target write in the same cycle) and judge the request.
    task automatic step(string req, logic [TAPS-1:0] a, logic [TAPS-1:0] b, bit pw,
                        bit ld, int newt);
        int exp;
        @(negedge clk);
        check({req, " ready"}, vec_ready, 1);
        nor_taps = a; nand_taps = b; mode_power = pw; vec_valid = 1;
        cal_load = ld; cal_target = CW'(newt);
        exp = code_of(lvl_of(a), lvl_of(b), model_target, pw);
        if (gap_of(a) || gap_of(b)) model_err = 1;
        if (ld) model_target = newt;
        @(negedge clk);
        vec_valid = 0; cal_load = 0;
        check({req, " req_valid"}, req_valid, 1);
        check({req, " code"}, req_code, exp);
        check({req, " err"}, tap_gap_err, model_err);
        req_ack = 1;
        @(negedge clk);
        req_ack = 0;
        check({req, " released"}, req_valid, 0);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                done = 1;
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h1234abcd));
        #(CLK_HALF * 3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", vec_ready, 1);
        check("R1 req_valid", req_valid, 0);
        check("R1 err", tap_gap_err, 0);
        // R1/R6 default target 4: taps 1..4 give hold
        step("R6 at target", 7'b0001111, 7'b0000011, 0, 0, 0);
        // R2/R4 below and above in performance mode
        step("R4 below", 7'b0000001, 7'b0000000, 0, 0, 0);
        step("R4 above", 7'b0111111, 7'b0000000, 0, 0, 0);
        // R2 empty vector -> level 0
        step("R2 zero", 7'b0000000, 7'b0000000, 1, 0, 0);
        // R5 power mode, R3 max of chains
        step("R5 above R3", 7'b0000011, 7'b1111111, 1, 0, 0);
        step("R3 nand lower", 7'b0001111, 7'b0000001, 1, 0, 0);
        // R10 target write coinciding with acceptance: old target 4 -> hold
        step("R10 same edge", 7'b0001111, 7'b0000000, 0, 1, 2);
        step("R10 new target", 7'b0000011, 7'b0000000, 0, 0, 0);
        step("R10 above new", 7'b0001111, 7'b0000000, 1, 0, 0);
        // R9 gap pattern: level from highest bit (3) vs target 2
        step("R9 gap", 7'b0000100, 7'b0000000, 0, 0, 0);
        step("R9 sticky", 7'b0000011, 7'b0000011, 0, 0, 0);
        // R8 vectors during pending request are ignored
        @(negedge clk);
        nor_taps = 7'b1111111; nand_taps = 0; mode_power = 0; vec_valid = 1;
        @(negedge clk);
        check("R8 pending code", req_code, code_of(7, 0, model_target, 0));
        nor_taps = 7'b0000000;
        repeat (3) @(negedge clk);
        check("R8 not ready", vec_ready, 0);
        check("R8 code stable", req_code, 2);
        vec_valid = 0;
        req_ack = 1;
        @(negedge clk);
        req_ack = 0;
        check("R8 released", req_valid, 0);
        @(negedge clk);
        check("R8 no extra req", req_valid, 0);
        // Random phase
        for (int n = 0; n < 300; n++) begin
            logic [TAPS-1:0] a, b;
            int la, lb;
            la = $urandom_range(0, TAPS);
            lb = $urandom_range(0, TAPS);
            a = ($urandom_range(0, 9) == 0) ? TAPS'($urandom) : TAPS'((1 << la) - 1);
            b = ($urandom_range(0, 9) == 0) ? TAPS'($urandom) : TAPS'((1 << lb) - 1);
            step("R4 R5 R6 random", a, b, 1'($urandom), ($urandom_range(0, 4) == 0),
                 $urandom_range(0, TAPS));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule